// File: doc/BRIEF.md
# Multiply-Divide Unit with HI/LO Result Registers

This block performs 32-bit integer multiplication and division for a simple in-order processor core. It keeps the two result registers, HI and LO, that hold the upper and lower halves of a 64-bit product or the remainder and quotient of a division. A 3-bit command selects one of eight operations each cycle. Every operation finishes in the cycle it is presented: HI and LO take their new values on that rising clock edge.

HI and LO drive output ports at all times, so register-read instructions can take them combinationally. A separate product output carries the low 32 bits of the operand product in the same cycle. This serves the three-operand multiply that writes a general-purpose register without disturbing HI and LO.

The next-value logic is built around a decoded command kind. The kinds are idle, signed multiply, unsigned multiply, signed divide, unsigned divide, set-HI, set-LO and low-multiply. The transitions of the HI/LO state are: hold (idle, low-multiply, divide by zero), load-product, load-quotient/remainder, load-HI-only, load-LO-only, and clear (on reset).

Top module: `mdu_top`

## Requirements
- R1: A synchronous active-high reset clears HI and LO to 0x00000000 on the next rising edge.
- R2: Command 0 (idle) leaves HI and LO unchanged.
- R3: Command 1 multiplies op_a by op_b as signed two's-complement values. After the edge, HI holds product bits 63..32 and LO holds bits 31..0.
- R4: Command 2 multiplies op_a by op_b as unsigned values, with the same HI/LO split as R3.
- R5: Command 3 divides op_a by op_b as signed values. LO receives the quotient truncated toward zero and HI receives the remainder, which has the sign of the dividend. 0x80000000 divided by 0xFFFFFFFF gives LO=0x80000000 and HI=0.
- R6: Command 4 divides op_a by op_b as unsigned values. The quotient goes to LO and the remainder to HI.
- R7: Command 3 or 4 with op_b equal to zero leaves HI and LO unchanged.
- R8: Command 5 copies op_a into HI and leaves LO unchanged. Command 6 copies op_a into LO and leaves HI unchanged.
- R9: prod always equals the low 32 bits of op_a*op_b in the same cycle, whatever the command. Command 7 leaves HI and LO unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Operation code 0..7 |
| op_a | input | 32 | First operand, dividend, or value for a HI/LO write |
| op_b | input | 32 | Second operand or divisor |
| hi | output | 32 | HI register |
| lo | output | 32 | LO register |
| prod | output | 32 | Low 32 bits of op_a*op_b, combinational |

## Verification
Multiplies use operand pairs with mixed signs, all-ones values and large magnitudes. Under a signed multiply the all-ones pair yields HI=0, while an unsigned multiply yields a large HI, so this pair tells the two sign modes apart. Divides run every sign combination of dividend and divisor, which exposes a wrong truncation direction or wrong remainder sign; the most-negative dividend over minus one checks the overflow corner. Divide-by-zero, idle and low-multiply commands are each issued right after a register write that left distinct values in HI and LO, so any unwanted update shows at the outputs.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
    localparam int unsigned CMD_W = 3;

    typedef enum logic [CMD_W-1:0] {
        CMD_IDLE   = 3'd0,
        CMD_MULS   = 3'd1,
        CMD_MULU   = 3'd2,
        CMD_DIVS   = 3'd3,
        CMD_DIVU   = 3'd4,
        CMD_SETHI  = 3'd5,
        CMD_SETLO  = 3'd6,
        CMD_MULLOW = 3'd7
    } mdu_cmd_e;
endpackage

// File: rtl/mdu_mult.sv
module mdu_mult #(
    parameter int unsigned W = 32
) (
    input  logic         sgn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] p_hi,
    output logic [W-1:0] p_lo
);
    localparam int unsigned PW = 2 * W;

    logic [PW-1:0] ext_a, ext_b, full;

    always_comb begin
        ext_a = {{W{sgn & a[W-1]}}, a};
        ext_b = {{W{sgn & b[W-1]}}, b};
        full  = ext_a * ext_b;
        p_hi  = full[PW-1:W];
        p_lo  = full[W-1:0];
    end
endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
    parameter int unsigned W = 32
) (
    input  logic         sgn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         by_zero
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    logic [W-1:0] b_safe;
    logic         ovf;

    always_comb begin
        by_zero = (b == '0);
        b_safe  = by_zero ? {{(W-1){1'b0}}, 1'b1} : b;
        ovf     = sgn && (a == MOST_NEG) && (b == ALL_ONES);
        if (ovf) begin
            quo = MOST_NEG;
            rem = '0;
        end else if (sgn) begin
            quo = $unsigned($signed(a) / $signed(b_safe));
            rem = $unsigned($signed(a) % $signed(b_safe));
        end else begin
            quo = a / b_safe;
            rem = a % b_safe;
        end
    end
endmodule

// File: rtl/mdu_top.sv
module mdu_top
    import mdu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [2:0]   cmd,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo,
    output logic [W-1:0] prod
);
    mdu_cmd_e     kind;
    logic [W-1:0] hi_q, lo_q, hi_d, lo_d;
    logic [W-1:0] m_hi, m_lo, d_quo, d_rem;
    logic         d_zero;

    assign kind = mdu_cmd_e'(cmd);

    mdu_mult #(.W(W)) u_mult (
        .sgn (kind == CMD_MULS),
        .a   (op_a),
        .b   (op_b),
        .p_hi(m_hi),
        .p_lo(m_lo)
    );

    mdu_div #(.W(W)) u_div (
        .sgn    (kind == CMD_DIVS),
        .a      (op_a),
        .b      (op_b),
        .quo    (d_quo),
        .rem    (d_rem),
        .by_zero(d_zero)
    );

    // next-state selection per command kind
    always_comb begin
        hi_d = hi_q;
        lo_d = lo_q;
        unique case (kind)
            CMD_IDLE, CMD_MULLOW: ;
            CMD_MULS, CMD_MULU: begin
                hi_d = m_hi;
                lo_d = m_lo;
            end
            CMD_DIVS, CMD_DIVU: begin
                if (!d_zero) begin
                    hi_d = d_rem;
                    lo_d = d_quo;
                end
            end
            CMD_SETHI: hi_d = op_a;
            CMD_SETLO: lo_d = op_a;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            hi_q <= hi_d;
            lo_q <= lo_d;
        end
    end

    assign hi   = hi_q;
    assign lo   = lo_q;
    assign prod = m_lo;

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        cmd == 3'd0 |=> $stable(hi) && $stable(lo));

    p_divzero_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd3 || cmd == 3'd4) && op_b == '0 |=> $stable(hi) && $stable(lo));

    p_sethi_r8: assert property (@(posedge clk) disable iff (rst)
        cmd == 3'd5 |=> hi == $past(op_a) && $stable(lo));

    p_setlo_r8: assert property (@(posedge clk) disable iff (rst)
        cmd == 3'd6 |=> lo == $past(op_a) && $stable(hi));

    p_mullow_hold_r9: assert property (@(posedge clk) disable iff (rst)
        cmd == 3'd7 |=> $stable(hi) && $stable(lo));

    p_mulu_zero_r4: assert property (@(posedge clk) disable iff (rst)
        cmd == 3'd2 && op_b == '0 |=> hi == '0 && lo == '0);
endmodule

// File: tb/test_mdu_top.sv
module test_mdu_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cmd = 3'd0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [31:0] hi, lo, prod;

    int errors = 0;
    int checks = 0;

    logic [95:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] m_hi = '0, m_lo = '0;

    always #10 clk = ~clk;

    mdu_top i_mdu_top (
        .clk(clk), .rst(rst), .cmd(cmd),
        .op_a(op_a), .op_b(op_b),
        .hi(hi), .lo(lo), .prod(prod)
    );

    task automatic drive(input logic [2:0] c, input logic [31:0] a,
                         input logic [31:0] b, input string tag);
        logic [63:0] p;
        logic [31:0] ua, ub, uq, ur;
        @(negedge clk);
        #1;
        cmd = c; op_a = a; op_b = b;
        case (c)
            3'd1: begin
                p = {{32{a[31]}}, a} * {{32{b[31]}}, b};
                m_hi = p[63:32]; m_lo = p[31:0];
            end
            3'd2: begin
                p = {32'b0, a} * {32'b0, b};
                m_hi = p[63:32]; m_lo = p[31:0];
            end
            3'd3: if (b != 0) begin
                ua = a[31] ? -a : a;
                ub = b[31] ? -b : b;
                uq = ua / ub; ur = ua % ub;
                m_lo = (a[31] ^ b[31]) ? -uq : uq;
                m_hi = a[31] ? -ur : ur;
            end
            3'd4: if (b != 0) begin
                m_lo = a / b; m_hi = a % b;
            end
            3'd5: m_hi = a;
            3'd6: m_lo = a;
            default: ;
        endcase
        exp_q.push_back({m_hi, m_lo, a * b});
        tag_q.push_back(tag);
    endtask

    // monitor: compares at negedge, before the driver changes inputs
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [95:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({hi, lo} !== e[95:32]) begin
                errors++;
                $display("FAIL %s: hi/lo got %h_%h expected %h_%h", t, hi, lo, e[95:64], e[63:32]);
            end
            checks++;
            if (prod !== e[31:0]) begin
                errors++;
                $display("FAIL %s/R9: prod got %h expected %h", t, prod, e[31:0]);
            end
        end
    end

    initial begin
        #(20 * 5000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        drive(3'd0, 32'h0000_0005, 32'h0000_0007, "R1");   // reset state, prod 35
        drive(3'd5, 32'hAAAA_0001, 32'h0, "R8");
        drive(3'd6, 32'h5555_0002, 32'h0, "R8");
        drive(3'd0, 32'h1234_5678, 32'h9ABC_DEF0, "R2");
        drive(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");    // -1*-1
        drive(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4");
        drive(3'd1, 32'h8000_0000, 32'h0000_0003, "R3");
        drive(3'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFE, "R3");
        drive(3'd2, 32'h8000_0000, 32'h0000_0003, "R4");
        drive(3'd3, 32'hFFFF_FFF9, 32'h0000_0002, "R5");    // -7/2
        drive(3'd3, 32'h0000_0007, 32'hFFFF_FFFE, "R5");    // 7/-2
        drive(3'd3, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R5");    // -7/-2
        drive(3'd3, 32'h0000_0007, 32'h0000_0002, "R5");
        drive(3'd3, 32'h8000_0000, 32'hFFFF_FFFF, "R5");
        drive(3'd4, 32'hFFFF_FFF9, 32'h0000_0002, "R6");
        drive(3'd4, 32'h0000_0003, 32'h0000_0010, "R6");
        drive(3'd5, 32'h1111_2222, 32'h0, "R8");
        drive(3'd3, 32'h0000_0064, 32'h0, "R7");
        drive(3'd4, 32'hFFFF_0000, 32'h0, "R7");
        drive(3'd7, 32'hFFFF_FFFD, 32'h0000_0006, "R9");
        drive(3'd7, 32'h0001_0001, 32'h0001_0001, "R9");
        drive(3'd6, 32'hDEAD_BEEF, 32'h0, "R8");
        drive(3'd0, 32'h0, 32'h0, "R2");
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule